// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits beside an 8-bit processor core and decides which interrupt the core should take next. It watches 32 maskable vectors. Each vector has a 2-bit software level, and software writes these levels through a small register port. Among the pending vectors, the one with the highest software level wins. When two vectors share a level, the lower vector index wins. The winner is offered to the core only if its level is strictly above the level of the handler now running.

When the core acknowledges a request, the running level is pushed onto an internal level stack and the accepted level takes its place. A return-from-interrupt strobe restores the saved level. Two special requests bypass the software levels:
- A trap request is offered whatever the global mask and the running level.
- A reset request overrides everything, including a trap. Accepting it empties the stack.

Forty external sources feed eleven shared vectors. Each source holds its own pending flag. A shared vector is asserted while any source in its group has its flag set, and each source has its own clear input.

Top module: `intc_top`

## Requirements
- R1: After reset, every vector's level reads 2'b10, `curLevel` is 2'b11 (main program) and `reqKind` is 2'b00 (none).
- R2: A write on the configuration port stores `cfgData` as the level of vector `cfgAddr`, and `cfgRdata` returns the level of vector `cfgAddr` in the same cycle. A write of 2'b11 is ignored.
- R3: Level codes rank 2'b00 highest, then 2'b01, then 2'b10. Among pending vectors the highest-ranked one is presented as `reqKind` 2'b01 with its number on `reqVector`. On equal rank the lower index is presented.
- R4: A vector is presented only if its rank is strictly above that of `curLevel`. An equal or lower rank gives `reqKind` 2'b00.
- R5: While `globalMask` is 1, no maskable vector is presented.
- R6: An acknowledge of a maskable request pushes `curLevel` and loads the vector's level one cycle later. Each `iretStrobe` restores the most recently saved level.
- R7: `iretStrobe` with an empty stack leaves `curLevel` unchanged. An acknowledge while `reqKind` is 2'b00 has no effect.
- R8: `trapReq` is presented as `reqKind` 2'b10 regardless of `globalMask` and `curLevel`. Its acknowledge pushes `curLevel` and sets it to 2'b00.
- R9: `resetReq` is presented as `reqKind` 2'b11 above a trap and above all vectors. Its acknowledge sets `curLevel` to 2'b11 and empties the stack, so a later `iretStrobe` has no effect.
- R10: The level stack holds STACK_DEPTH (5) entries. While it is full, neither a trap nor a maskable vector is presented.
- R11: An `extSet[i]` pulse sets the pending flag of source i, and `extClr[i]` clears it; if both arrive in the same cycle, the set wins. Source i belongs to group i mod 11, and group g drives vector 8+g from the cycle after the flag is set until every source in the group is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLine | input | 32 | Level pending lines, one per vector |
| extSet | input | 40 | Set pulse per external source |
| extClr | input | 40 | Clear pulse per external source |
| globalMask | input | 1 | Blocks all maskable vectors when 1 |
| trapReq | input | 1 | Trap request |
| resetReq | input | 1 | Reset request |
| cfgWe | input | 1 | Level write enable |
| cfgAddr | input | 5 | Vector selected for write and read |
| cfgData | input | 2 | Level to write |
| cfgRdata | output | 2 | Level of the selected vector |
| ackStrobe | input | 1 | Core accepts the presented request |
| iretStrobe | input | 1 | Core returns from a handler |
| reqKind | output | 2 | 00 none, 01 vector, 10 trap, 11 reset |
| reqVector | output | 5 | Presented vector number (0 unless kind 01) |
| reqLevel | output | 2 | Level of the presented request |
| curLevel | output | 2 | Level of the running handler |

## Verification
A corrupted level stack or running level cannot be seen directly. It shows at the ports as wrong preemption: an equal-level vector that gets through, or a higher one that is held back. The bench therefore checks `reqKind` right after every acknowledge and after every return, and reads `curLevel` one cycle after each strobe. An arbitration fault shows the same cycle the pending pattern is applied. An external group fault shows one cycle after a set or clear pulse.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_IRQ   = 2'b01,
    KIND_TRAP  = 2'b10,
    KIND_RESET = 2'b11
  } req_kind_e;

  localparam logic [1:0] LVL_MAIN = 2'b11;
  localparam logic [1:0] LVL_LOW  = 2'b10;
  localparam logic [1:0] LVL_MID  = 2'b01;
  localparam logic [1:0] LVL_TOP  = 2'b00;

  typedef struct packed {
    logic takeIrq;
    logic takeTrap;
    logic takeReset;
    logic popLevel;
  } ctrl_strobe_t;

  // Larger rank means more urgent; the main-program code ranks lowest.
  function automatic logic [1:0] levelRank(input logic [1:0] code);
    return ~code;
  endfunction

endpackage

// File: rtl/intc_ext_groups.sv
`timescale 1ns/1ps
module intc_ext_groups #(
  parameter int NUM_SRC = 40,
  parameter int NUM_GRP = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] extSet,
  input  logic [NUM_SRC-1:0] extClr,
  output logic [NUM_GRP-1:0] grpPending
);

  logic [NUM_SRC-1:0] memberPend;

  always_ff @(posedge clk) begin
    if (!rstN) memberPend <= '0;
    else       memberPend <= (memberPend & ~extClr) | extSet;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : gen_group
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int m = 0; m < NUM_SRC; m++) begin
        if ((m % NUM_GRP) == g) hit = hit | memberPend[m];
      end
    end
    assign grpPending[g] = hit;
  end

  AST_GROUP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (|(extSet)) |=> (|grpPending)); // R11

endmodule

// File: rtl/intc_datapath.sv
`timescale 1ns/1ps
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_VEC     = 32,
  parameter int STACK_DEPTH = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_VEC-1:0]         pending,
  input  logic                       cfgWe,
  input  logic [$clog2(NUM_VEC)-1:0] cfgAddr,
  input  logic [1:0]                 cfgData,
  output logic [1:0]                 cfgRdata,
  input  ctrl_strobe_t               strobe,
  output logic                       bestValid,
  output logic [$clog2(NUM_VEC)-1:0] bestVec,
  output logic [1:0]                 bestLevel,
  output logic [1:0]                 curLevel,
  output logic                       stackFull,
  output logic                       stackEmpty
);

  localparam int VEC_W = $clog2(NUM_VEC);
  localparam int CNT_W = $clog2(STACK_DEPTH + 1);

  // Software level table
  logic [1:0] prioTab [NUM_VEC];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_VEC; i++) prioTab[i] <= LVL_LOW;
    end else if (cfgWe && (cfgData != LVL_MAIN)) begin
      prioTab[cfgAddr] <= cfgData;
    end
  end

  assign cfgRdata = prioTab[cfgAddr];

  // Arbiter: scan from the top index down so that on equal rank a lower index overrides.
  always_comb begin
    bestValid = 1'b0;
    bestVec   = '0;
    bestLevel = LVL_MAIN;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (pending[i] && (!bestValid || (levelRank(prioTab[i]) >= levelRank(bestLevel)))) begin
        bestValid = 1'b1;
        bestVec   = VEC_W'(i);
        bestLevel = prioTab[i];
      end
    end
  end

  // Level stack
  logic [1:0]       stackMem [STACK_DEPTH];
  logic [CNT_W-1:0] stackCnt;
  logic [CNT_W-1:0] topIdx;
  logic [1:0]       curLvl;
  logic             pushLvl;

  assign pushLvl    = strobe.takeIrq | strobe.takeTrap;
  assign topIdx     = stackCnt - CNT_W'(1);
  assign stackFull  = (stackCnt == CNT_W'(STACK_DEPTH));
  assign stackEmpty = (stackCnt == '0);
  assign curLevel   = curLvl;

  always_ff @(posedge clk) begin
    if (pushLvl && !stackFull) stackMem[stackCnt] <= curLvl;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stackCnt <= '0;
      curLvl   <= LVL_MAIN;
    end else if (strobe.takeReset) begin
      stackCnt <= '0;
      curLvl   <= LVL_MAIN;
    end else if (pushLvl && !stackFull) begin
      stackCnt <= stackCnt + CNT_W'(1);
      curLvl   <= strobe.takeTrap ? LVL_TOP : bestLevel;
    end else if (strobe.popLevel && !stackEmpty) begin
      stackCnt <= topIdx;
      curLvl   <= stackMem[topIdx];
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    pushLvl |-> !stackFull); // R10
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popLevel |-> !stackEmpty); // R7
  AST_IRQ_LEVEL_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeIrq |=> (curLevel == $past(bestLevel))); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeReset |=> (stackEmpty && curLevel == LVL_MAIN)); // R9
  AST_TABLE_NO_MAIN: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdata != LVL_MAIN); // R2

endmodule

// File: rtl/intc_control.sv
`timescale 1ns/1ps
module intc_control
  import intc_pkg::*;
#(
  parameter int NUM_VEC = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       bestValid,
  input  logic [$clog2(NUM_VEC)-1:0] bestVec,
  input  logic [1:0]                 bestLevel,
  input  logic [1:0]                 curLevel,
  input  logic                       stackFull,
  input  logic                       stackEmpty,
  input  logic                       globalMask,
  input  logic                       trapReq,
  input  logic                       resetReq,
  input  logic                       ackStrobe,
  input  logic                       iretStrobe,
  output req_kind_e                  reqKind,
  output logic [$clog2(NUM_VEC)-1:0] reqVector,
  output logic [1:0]                 reqLevel,
  output ctrl_strobe_t               strobe
);

  logic irqEligible;
  logic ackTaken;

  assign irqEligible = bestValid && !globalMask && !stackFull &&
                       (levelRank(bestLevel) > levelRank(curLevel));

  always_comb begin
    reqKind   = KIND_NONE;
    reqVector = '0;
    reqLevel  = LVL_MAIN;
    if (resetReq) begin
      reqKind = KIND_RESET;
    end else if (trapReq && !stackFull) begin
      reqKind  = KIND_TRAP;
      reqLevel = LVL_TOP;
    end else if (irqEligible) begin
      reqKind   = KIND_IRQ;
      reqVector = bestVec;
      reqLevel  = bestLevel;
    end
  end

  assign ackTaken         = ackStrobe && (reqKind != KIND_NONE);
  assign strobe.takeIrq   = ackStrobe && (reqKind == KIND_IRQ);
  assign strobe.takeTrap  = ackStrobe && (reqKind == KIND_TRAP);
  assign strobe.takeReset = ackStrobe && (reqKind == KIND_RESET);
  assign strobe.popLevel  = iretStrobe && !ackTaken && !stackEmpty;

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    globalMask |-> (reqKind != KIND_IRQ)); // R5
  AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqKind == KIND_IRQ) |-> (levelRank(reqLevel) > levelRank(curLevel))); // R4
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (reqKind == KIND_RESET)); // R9
  AST_TRAP_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && !resetReq && !stackFull) |-> (reqKind == KIND_TRAP)); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.takeIrq, strobe.takeTrap, strobe.takeReset, strobe.popLevel})); // R7

endmodule

// File: rtl/intc_top.sv
`timescale 1ns/1ps
module intc_top
  import intc_pkg::*;
#(
  parameter int NUM_VEC     = 32,
  parameter int NUM_EXT     = 40,
  parameter int NUM_GRP     = 11,
  parameter int EXT_BASE    = 8,
  parameter int STACK_DEPTH = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_VEC-1:0]         irqLine,
  input  logic [NUM_EXT-1:0]         extSet,
  input  logic [NUM_EXT-1:0]         extClr,
  input  logic                       globalMask,
  input  logic                       trapReq,
  input  logic                       resetReq,
  input  logic                       cfgWe,
  input  logic [$clog2(NUM_VEC)-1:0] cfgAddr,
  input  logic [1:0]                 cfgData,
  output logic [1:0]                 cfgRdata,
  input  logic                       ackStrobe,
  input  logic                       iretStrobe,
  output logic [1:0]                 reqKind,
  output logic [$clog2(NUM_VEC)-1:0] reqVector,
  output logic [1:0]                 reqLevel,
  output logic [1:0]                 curLevel
);

  localparam int VEC_W = $clog2(NUM_VEC);

  logic [NUM_GRP-1:0] grpPending;
  logic [NUM_VEC-1:0] pending;
  logic               bestValid;
  logic [VEC_W-1:0]   bestVec;
  logic [1:0]         bestLevel;
  logic               stackFull;
  logic               stackEmpty;
  ctrl_strobe_t       strobe;
  req_kind_e          kindOut;

  intc_ext_groups #(.NUM_SRC(NUM_EXT), .NUM_GRP(NUM_GRP)) u_groups (
    .clk(clk), .rstN(rstN), .extSet(extSet), .extClr(extClr), .grpPending(grpPending)
  );

  always_comb begin
    pending = irqLine;
    for (int g = 0; g < NUM_GRP; g++) pending[EXT_BASE + g] = pending[EXT_BASE + g] | grpPending[g];
  end

  intc_datapath #(.NUM_VEC(NUM_VEC), .STACK_DEPTH(STACK_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .pending(pending),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData), .cfgRdata(cfgRdata),
    .strobe(strobe), .bestValid(bestValid), .bestVec(bestVec), .bestLevel(bestLevel),
    .curLevel(curLevel), .stackFull(stackFull), .stackEmpty(stackEmpty)
  );

  intc_control #(.NUM_VEC(NUM_VEC)) u_ctrl (
    .clk(clk), .rstN(rstN), .bestValid(bestValid), .bestVec(bestVec), .bestLevel(bestLevel),
    .curLevel(curLevel), .stackFull(stackFull), .stackEmpty(stackEmpty),
    .globalMask(globalMask), .trapReq(trapReq), .resetReq(resetReq),
    .ackStrobe(ackStrobe), .iretStrobe(iretStrobe),
    .reqKind(kindOut), .reqVector(reqVector), .reqLevel(reqLevel), .strobe(strobe)
  );

  assign reqKind = kindOut;

endmodule

// File: tb/intc_top_bench.sv
`timescale 1ns/1ps
module intc_top_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] irqLine;
  logic [39:0] extSet, extClr;
  logic        globalMask, trapReq, resetReq;
  logic        cfgWe;
  logic [4:0]  cfgAddr;
  logic [1:0]  cfgData, cfgRdata;
  logic        ackStrobe, iretStrobe;
  logic [1:0]  reqKind, reqLevel, curLevel;
  logic [4:0]  reqVector;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  intc_top u_intc_top (
    .clk(clk), .rstN(rstN), .irqLine(irqLine), .extSet(extSet), .extClr(extClr),
    .globalMask(globalMask), .trapReq(trapReq), .resetReq(resetReq),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData), .cfgRdata(cfgRdata),
    .ackStrobe(ackStrobe), .iretStrobe(iretStrobe),
    .reqKind(reqKind), .reqVector(reqVector), .reqLevel(reqLevel), .curLevel(curLevel)
  );

  // {mask, expected kind, expected vector, pending}; levels: v5,v7=01, v20,v30=00, others 10
  localparam logic [39:0] VEC_TAB [0:7] = '{
    {1'b0, 2'b01, 5'd1,  32'h0000_000A},
    {1'b0, 2'b01, 5'd5,  32'h0000_0022},
    {1'b0, 2'b01, 5'd5,  32'h0000_00A0},
    {1'b0, 2'b01, 5'd20, 32'h4010_0020},
    {1'b0, 2'b01, 5'd30, 32'hC000_0000},
    {1'b0, 2'b00, 5'd0,  32'h0000_0000},
    {1'b1, 2'b00, 5'd0,  32'h0010_0000},
    {1'b0, 2'b01, 5'd31, 32'h8000_0000}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic doAck();
    ackStrobe = 1'b1; step(); ackStrobe = 1'b0;
  endtask

  task automatic doIret();
    iretStrobe = 1'b1; step(); iretStrobe = 1'b0;
  endtask

  task automatic cfgWrite(input logic [4:0] a, input logic [1:0] d);
    cfgAddr = a; cfgData = d; cfgWe = 1'b1; step(); cfgWe = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; irqLine = '0; extSet = '0; extClr = '0;
    globalMask = 1'b0; trapReq = 1'b0; resetReq = 1'b0;
    cfgWe = 1'b0; cfgAddr = '0; cfgData = '0; ackStrobe = 1'b0; iretStrobe = 1'b0;
    repeat (3) step();
    rstN = 1'b1; step();

    // R1 reset state
    chk("R1 reqKind", reqKind, 0);
    chk("R1 curLevel", curLevel, 3);
    cfgAddr = 5'd17; #1;
    chk("R1 level of v17", cfgRdata, 2);

    // R2 configuration port
    cfgWrite(5'd5, 2'b01); cfgWrite(5'd7, 2'b01);
    cfgWrite(5'd20, 2'b00); cfgWrite(5'd30, 2'b00);
    cfgAddr = 5'd20; #1;
    chk("R2 readback v20", cfgRdata, 0);
    cfgWrite(5'd5, 2'b11);
    cfgAddr = 5'd5; #1;
    chk("R2 write 11 ignored", cfgRdata, 1);

    // R3 / R5 arbitration table
    for (int k = 0; k < 8; k++) begin
      globalMask = VEC_TAB[k][39];
      irqLine    = VEC_TAB[k][31:0];
      #1;
      chk($sformatf("R3 R5 table %0d kind", k), reqKind, int'(VEC_TAB[k][38:37]));
      chk($sformatf("R3 R5 table %0d vector", k), reqVector, int'(VEC_TAB[k][36:32]));
    end
    globalMask = 1'b0; irqLine = '0; #1;

    // R12-free ack with nothing presented: R7
    doAck();
    chk("R7 ack with none", curLevel, 3);

    // R4 / R6 nesting
    irqLine = 32'h0000_0002; #1;
    chk("R4 v1 over main", reqKind, 1);
    doAck();
    chk("R6 level after v1", curLevel, 2);
    irqLine = 32'h0000_000A; #1;
    chk("R4 equal level blocked", reqKind, 0);
    irqLine = 32'h0000_002A; #1;
    chk("R4 higher v5 presented", reqVector, 5);
    doAck();
    chk("R6 level after v5", curLevel, 1);
    irqLine = 32'h0000_00AA; #1;
    chk("R4 v7 equal blocked", reqKind, 0);
    irqLine = 32'h0010_00AA; #1;
    chk("R4 v20 presented", reqVector, 20);
    doAck();
    chk("R6 level after v20", curLevel, 0);
    irqLine = 32'h4010_00AA; #1;
    chk("R4 v30 at top blocked", reqKind, 0);
    irqLine = '0;
    doIret(); chk("R6 pop to 01", curLevel, 1);
    doIret(); chk("R6 pop to 10", curLevel, 2);
    doIret(); chk("R6 pop to main", curLevel, 3);
    doIret(); chk("R7 pop on empty", curLevel, 3);

    // R8 trap ignores mask
    globalMask = 1'b1; irqLine = 32'h0010_0000; trapReq = 1'b1; #1;
    chk("R8 trap under mask", reqKind, 2);
    doAck();
    chk("R8 trap level", curLevel, 0);
    trapReq = 1'b0; globalMask = 1'b0; irqLine = '0;
    doIret();
    chk("R8 return from trap", curLevel, 3);

    // R9 reset above trap, clears stack
    irqLine = 32'h0000_0002; doAck();
    chk("R9 setup level", curLevel, 2);
    trapReq = 1'b1; resetReq = 1'b1; #1;
    chk("R9 reset over trap", reqKind, 3);
    doAck();
    trapReq = 1'b0; resetReq = 1'b0; irqLine = '0;
    chk("R9 level after reset", curLevel, 3);
    doIret();
    chk("R9 stack emptied", curLevel, 3);

    // R10 stack full
    irqLine = 32'h0000_0002; #1; doAck();
    irqLine = 32'h0000_0020; #1; doAck();
    irqLine = 32'h0010_0000; #1; doAck();
    irqLine = '0; trapReq = 1'b1; #1;
    doAck(); doAck();
    chk("R10 full blocks trap", reqKind, 0);
    resetReq = 1'b1; trapReq = 1'b0; #1;
    doAck();
    resetReq = 1'b0; #1;
    chk("R10 recovered by reset", curLevel, 3);

    // R11 external groups
    extSet[13] = 1'b1; step(); extSet = '0; #1;
    chk("R11 src13 to v10 kind", reqKind, 1);
    chk("R11 src13 to v10 vector", reqVector, 10);
    extSet[24] = 1'b1; step(); extSet = '0;
    extClr[13] = 1'b1; step(); extClr = '0; #1;
    chk("R11 group held by src24", reqVector, 10);
    extClr[24] = 1'b1; extSet[24] = 1'b1; step(); extClr = '0; extSet = '0; #1;
    chk("R11 set wins over clear", reqVector, 10);
    extClr[24] = 1'b1; step(); extClr = '0; #1;
    chk("R11 group released", reqKind, 0);
    extSet[39] = 1'b1; extSet[0] = 1'b1; step(); extSet = '0; #1;
    chk("R11 v8 beats v14", reqVector, 8);
    extClr[0] = 1'b1; step(); extClr = '0; #1;
    chk("R11 src39 to v14", reqVector, 14);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule